// File: doc/BRIEF.md
# Floating-Point Result Class Encoder

This block inspects a 64-bit IEEE-754 double-precision value and reduces it to a 5-bit class code. The code has five bits. Bit 4 is a class qualifier. Bits 3..0 are condition flags for negative, positive, zero and unordered. When a request strobe is high, the block replaces a 5-bit field inside a 32-bit floating-point status word with that code. Both the new status word and the code are presented from registers.

The unit sits just behind a floating-point result path. Whenever the pipeline wants the class field refreshed, it sends the result value and the current status word. The rewritten status word comes back on the next clock edge. Bits outside the class field pass through unchanged. The old contents of the field never affect the new value. The position of the field is a parameter (`FIELD_LSB`, default 12).

Top module: `fp_class_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, `status_out` and `class_code` become zero at that edge.
- R2: A quiet NaN produces class code 0x11 for either sign. A quiet NaN has exponent bits [62:52] all ones and fraction bit 51 set.
- R3: A signaling NaN produces class code 0x00 for either sign. A signaling NaN has exponent all ones, fraction bits [51:0] nonzero and bit 51 clear.
- R4: An infinity (exponent all ones, fraction zero) produces 0x05 when bit 63 is 0 and 0x09 when bit 63 is 1.
- R5: A zero (exponent and fraction all zero) produces 0x02 when positive and 0x12 when negative.
- R6: A normal number (exponent neither all zeros nor all ones) produces 0x04 when positive and 0x08 when negative.
- R7: A denormal (exponent all zeros, fraction nonzero) produces 0x14 when positive and 0x18 when negative.
- R8: On an accepted request, `status_out` equals `status_in` with bits [FIELD_LSB+4:FIELD_LSB] replaced by the class code. Earlier contents of those bits have no effect.
- R9: A request with `in_valid` high at edge k is visible on both outputs after edge k. While `in_valid` is low, both outputs hold their values whatever `operand` and `status_in` carry.
- R10: Classification priority is NaN, then infinity, then zero, then denormal versus normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe: classify and rewrite the field |
| operand | input | 64 | Double-precision value to classify |
| status_in | input | 32 | Current status word |
| status_out | output | 32 | Registered status word with the class field rewritten |
| class_code | output | 5 | Registered class code of the last accepted operand |

## Verification
The assertions assume that `in_valid`, `operand` and `status_in` are stable and known around each rising edge. They also assume that only the cycle right after a request relates the outputs to the inputs. The stimulus drives every input on the falling edge and reads the outputs on the next falling edge, so each request is checked against the values sampled at one edge. The sweep crosses exponent values at both extremes and their neighbours with fraction patterns that toggle bit 51, the lowest bit and all bits, for both signs. Each of these is applied over status words with the class field all ones, all zeros and mixed, so that a stale field bit would be exposed.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int CODE_W = 5;

    // meaning of each bit of the class code
    localparam logic [CODE_W-1:0] BIT_QUAL  = 5'h10;
    localparam logic [CODE_W-1:0] BIT_NEG   = 5'h08;
    localparam logic [CODE_W-1:0] BIT_POS   = 5'h04;
    localparam logic [CODE_W-1:0] BIT_ZERO  = 5'h02;
    localparam logic [CODE_W-1:0] BIT_UNORD = 5'h01;

    typedef enum logic [2:0] {
        CAT_SNAN   = 3'd0,
        CAT_QNAN   = 3'd1,
        CAT_INF    = 3'd2,
        CAT_ZERO   = 3'd3,
        CAT_DENORM = 3'd4,
        CAT_NORMAL = 3'd5
    } fp_cat_e;

    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic frac_top;
    } fp_flags_t;

    typedef struct packed {
        fp_cat_e cat;
        logic    sign;
    } fp_class_t;

    // priority: NaN, infinity, zero, denormal/normal (R10)
    function automatic fp_cat_e cat_of(fp_flags_t f);
        fp_cat_e c;
        if (f.exp_ones && !f.frac_zero)
            c = f.frac_top ? CAT_QNAN : CAT_SNAN;
        else if (f.exp_ones)
            c = CAT_INF;
        else if (f.exp_zero && f.frac_zero)
            c = CAT_ZERO;
        else if (f.exp_zero)
            c = CAT_DENORM;
        else
            c = CAT_NORMAL;
        return c;
    endfunction

    function automatic logic [CODE_W-1:0] sign_bit(logic s);
        return s ? BIT_NEG : BIT_POS;
    endfunction

    function automatic logic [CODE_W-1:0] code_of(fp_class_t k);
        logic [CODE_W-1:0] c;
        case (k.cat)
            CAT_SNAN:   c = '0;
            CAT_QNAN:   c = BIT_QUAL | BIT_UNORD;
            CAT_INF:    c = sign_bit(k.sign) | BIT_UNORD;
            CAT_ZERO:   c = k.sign ? (BIT_QUAL | BIT_ZERO) : BIT_ZERO;
            CAT_DENORM: c = BIT_QUAL | sign_bit(k.sign);
            default:    c = sign_bit(k.sign);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fpc_field_decode.sv
module fpc_field_decode
    import fpc_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0] operand,
    output fp_flags_t       flags
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = operand[FRAC_W +: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];

    always_comb begin
        flags.sign      = operand[OP_W-1];
        flags.exp_ones  = &exp_f;
        flags.exp_zero  = ~|exp_f;
        flags.frac_zero = ~|frac_f;
        flags.frac_top  = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fpc_class_map.sv
module fpc_class_map
    import fpc_pkg::*;
(
    input  fp_flags_t         flags,
    output fp_class_t         cls,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        cls.cat  = cat_of(flags);
        cls.sign = flags.sign;
        code     = code_of(cls);
    end
endmodule

// File: rtl/fpc_status_merge.sv
module fpc_status_merge
    import fpc_pkg::*;
#(
    parameter int STAT_W    = 32,
    parameter int FIELD_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [STAT_W-1:0] status_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [STAT_W-1:0] status_out,
    output logic [CODE_W-1:0] class_code
);
    localparam logic [STAT_W-1:0] FIELD_MASK =
        {{(STAT_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << FIELD_LSB;

    logic [STAT_W-1:0] placed;
    assign placed = {{(STAT_W-CODE_W){1'b0}}, code_in} << FIELD_LSB;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_out <= '0;
            class_code <= '0;
        end else if (in_valid) begin
            status_out <= (status_in & ~FIELD_MASK) | placed;
            class_code <= code_in;
        end
    end

    // R8: untouched bits come from the request word
    a_r8_outside_kept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((status_out & ~FIELD_MASK) == ($past(status_in) & ~FIELD_MASK)));

    // R8: field carries the code reported alongside it
    a_r8_field_code: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (status_out[FIELD_LSB +: CODE_W] == class_code));

    // R9: idle cycles leave both outputs alone
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(status_out) && $stable(class_code)));
endmodule

// File: rtl/fp_class_encoder.sv
module fp_class_encoder
    import fpc_pkg::*;
#(
    parameter int EXP_W     = 11,
    parameter int FRAC_W    = 52,
    parameter int STAT_W    = 32,
    parameter int FIELD_LSB = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [EXP_W+FRAC_W:0]         operand,
    input  logic [STAT_W-1:0]             status_in,
    output logic [STAT_W-1:0]             status_out,
    output logic [CODE_W-1:0]             class_code
);
    fp_flags_t         flags;
    fp_class_t         cls;
    logic [CODE_W-1:0] code;

    fpc_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
        .operand (operand),
        .flags   (flags)
    );

    fpc_class_map u_map (
        .flags (flags),
        .cls   (cls),
        .code  (code)
    );

    fpc_status_merge #(.STAT_W(STAT_W), .FIELD_LSB(FIELD_LSB)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .status_in  (status_in),
        .code_in    (code),
        .status_out (status_out),
        .class_code (class_code)
    );

    // input predicates taken straight from the port
    logic in_exp_max, in_exp_min, in_frac_nz;
    assign in_exp_max = (operand[FRAC_W +: EXP_W] == {EXP_W{1'b1}});
    assign in_exp_min = (operand[FRAC_W +: EXP_W] == '0);
    assign in_frac_nz = (operand[FRAC_W-1:0] != '0);

    // R4: infinities always carry the unordered flag and one sign flag
    a_r4_inf_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_exp_max && !in_frac_nz) |=>
            (class_code == 5'h05 || class_code == 5'h09));

    // R5: zero inputs set the zero flag
    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_exp_min && !in_frac_nz) |=> class_code[1]);

    // R7: denormals set the qualifier plus exactly one sign flag
    a_r7_denorm_bits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_exp_min && in_frac_nz) |=>
            (class_code[4] && $countones(class_code) == 2));

    // R3: NaNs with bit 51 clear yield no flags at all
    a_r3_snan_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_exp_max && in_frac_nz && !operand[FRAC_W-1]) |=>
            (class_code == '0));

    // R1: reset clears both registered outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status_out == '0 && class_code == '0));
endmodule

// File: tb/tb_fp_class_encoder.sv
`timescale 1ns/1ps
module tb_fp_class_encoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] operand;
    logic [31:0] status_in;
    logic [31:0] status_out;
    logic [4:0]  class_code;

    int vec_n  = 0;
    int fail_n = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fp_class_encoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .status_in(status_in), .status_out(status_out), .class_code(class_code)
    );

    // reference: arithmetic on exponent and fraction values
    function automatic logic [4:0] ref_code(logic [63:0] v);
        longint unsigned e = longint'(v[62:52]);
        longint unsigned f = longint'(v[51:0]);
        bit neg = v[63];
        if (e == 2047 && f != 0) return (f >= (64'd1 << 51)) ? 5'd17 : 5'd0;
        if (e == 2047) return neg ? 5'd9 : 5'd5;
        if (e == 0 && f == 0) return neg ? 5'd18 : 5'd2;
        if (e == 0) return neg ? 5'd24 : 5'd20;
        return neg ? 5'd8 : 5'd4;
    endfunction

    function automatic string req_of(logic [63:0] v);
        longint unsigned e = longint'(v[62:52]);
        longint unsigned f = longint'(v[51:0]);
        if (e == 2047 && f >= (64'd1 << 51)) return "R2/R10";
        if (e == 2047 && f != 0) return "R3/R10";
        if (e == 2047) return "R4/R10";
        if (e == 0 && f == 0) return "R5/R10";
        if (e == 0) return "R7/R10";
        return "R6";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            fail_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        fail_n++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        longint unsigned exps [5]  = '{0, 1, 1023, 2046, 2047};
        longint unsigned fracs [6] = '{0, 1, 64'h8_0000_0000_0000, 64'h8_0000_0000_0001,
                                       64'hF_FFFF_FFFF_FFFF, 64'h4_0000_0000_0000};
        logic [31:0] stats [3]     = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_5A5A};
        logic [31:0] mask = 32'h1F << 12;
        logic [31:0] last_s;
        logic [4:0]  last_c;

        rst = 1'b1; in_valid = 1'b0; operand = '0; status_in = '0;
        // preload junk so reset has something to clear
        @(negedge clk); rst = 1'b0; in_valid = 1'b1;
        operand = 64'h7FF0_0000_0000_0000; status_in = 32'hDEAD_BEEF;
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R1", status_out, 32'h0);
        check("R1", {27'd0, class_code}, 32'h0);
        rst = 1'b0;

        // full sweep: R2..R8, R10
        for (int si = 0; si < 3; si++)
            for (int sg = 0; sg < 2; sg++)
                for (int ei = 0; ei < 5; ei++)
                    for (int fi = 0; fi < 6; fi++) begin
                        logic [63:0] v;
                        logic [4:0]  c;
                        v = {sg[0], exps[ei][10:0], fracs[fi][51:0]};
                        c = ref_code(v);
                        @(negedge clk);
                        in_valid = 1'b1; operand = v; status_in = stats[si];
                        @(negedge clk);
                        check(req_of(v), {27'd0, class_code}, {27'd0, c});
                        check("R8", status_out, (stats[si] & ~mask) | (32'(c) << 12));
                    end

        // R9: one-cycle latency, then hold while idle
        @(negedge clk);
        in_valid = 1'b1; operand = 64'h8000_0000_0000_0001; status_in = 32'h0F0F_0F0F;
        @(negedge clk);
        check("R9", {27'd0, class_code}, 32'd24);
        last_s = status_out; last_c = class_code;
        in_valid = 1'b0; operand = 64'h7FF8_0000_0000_0000; status_in = 32'hFFFF_FFFF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", status_out, last_s);
            check("R9", {27'd0, class_code}, {27'd0, last_c});
            operand = operand ^ 64'hFFFF_0000_0000_1234;
            status_in = ~status_in;
        end

        // back-to-back requests: R9 latency with no gap
        in_valid = 1'b1; operand = 64'h7FF8_0000_0000_0000; status_in = 32'h0;
        @(negedge clk);
        check("R9", {27'd0, class_code}, 32'h11);
        operand = 64'h8000_0000_0000_0000;
        @(negedge clk);
        check("R9", {27'd0, class_code}, 32'h12);
        check("R8", status_out, 32'h12 << 12);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule